// File: doc/BRIEF.md
# Direct Page Address Generator

This block holds the base page used by direct-addressing-mode data accesses and forms the resulting addresses. An 8-bit page register sits on a small CPU register bus. When the CPU runs a direct-mode access, the instruction supplies an 8-bit operand. The block appends that operand below the page value to give a 16-bit local address. It also drives a 23-bit global address. The upper seven bits of the global address come from a global page input when the instruction is a global one. Otherwise they come from an external local-expansion input.

The page register has a protection scheme that depends on the operating mode. In special mode the CPU may rewrite it without limit. In normal mode only the first write after reset lands, and any write after that is dropped without notice. The same page value is used whether the chip runs a local or a global mapping scheme. The bus reset is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `dpg_top`

## Requirements
- R1: After reset the page register reads back 0x00.
- R2: Reading at the page register's bus address (default 0x04) returns the current page value combinationally, at any time. Reading any other address returns 0x00.
- R3: In special mode (`special_mode`=1), every write to the page register address takes effect at the next rising clock edge, whether or not the lock is set.
- R4: In normal mode (`special_mode`=0), only the first write after reset takes effect. Later normal-mode writes leave the value unchanged.
- R5: A special-mode write does not set the lock. A normal-mode write that follows only special-mode writes is still accepted.
- R6: `local_addr` equals {page register, `dir_operand`}, with the page value in bits [15:8] and the operand in bits [7:0].
- R7: With `glob_access`=1, `global_addr` equals {`gpage_in`, page register, `dir_operand`}, with `gpage_in` in bits [22:16].
- R8: With `glob_access`=0, `global_addr` equals {`lexp_in`, `local_addr`}, with `lexp_in` in bits [22:16].
- R9: Writes to any bus address other than the page register address change neither the page value nor the lock.
- R10: Reset clears the lock, so the first normal-mode write after a new reset is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| special_mode | input | 1 | 1 = special mode (page register writes unrestricted), 0 = normal mode (one write only) |
| bus_addr | input | 5 | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| dir_operand | input | 8 | Direct-mode operand from the instruction |
| glob_access | input | 1 | 1 = global instruction, 0 = local direct access |
| gpage_in | input | 7 | Global page bits for global direct accesses |
| lexp_in | input | 7 | Local-to-global expansion bits for local direct accesses |
| local_addr | output | 16 | Local direct address |
| global_addr | output | 23 | Global direct address |

## Verification
The page register and the lock flag are the only state in the block. A wrong page value shows up in the same cycle on `bus_rdata` and in bits [15:8] of both address outputs. Because of that, one readback after each write exposes it. A wrong lock flag is invisible until the next normal-mode write. So each lock scenario ends with a second write of a different value and a readback in the following cycle. That readback shows either a value that was wrongly kept or one that was wrongly accepted.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  // Classification of a register bus cycle against the page register
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,  // no write to the page register
    WR_FREE    = 2'd1,  // special-mode write, always taken, lock untouched
    WR_FIRST   = 2'd2,  // first normal-mode write, taken and locks
    WR_BLOCKED = 2'd3   // normal-mode write after lock, dropped
  } wr_kind_e;

  localparam int unsigned DPG_PAGE_W  = 8;
  localparam int unsigned DPG_OPER_W  = 8;
  localparam int unsigned DPG_GPAGE_W = 7;
  localparam int unsigned DPG_BUS_AW  = 5;

endpackage

// File: rtl/dpg_rst_sync.sv
module dpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dpg_page_reg.sv
module dpg_page_reg
  import dpg_pkg::*;
#(
  parameter int unsigned        PAGE_W   = DPG_PAGE_W,
  parameter int unsigned        BUS_AW   = DPG_BUS_AW,
  parameter logic [BUS_AW-1:0]  REG_ADDR = 5'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PAGE_W-1:0] bus_wdata,
  output logic [PAGE_W-1:0] bus_rdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              lock_q
);

  logic              hit;
  wr_kind_e          kind;
  logic              page_en;
  logic              lock_en;
  logic [PAGE_W-1:0] page_d;
  logic              lock_d;

  // Address decode
  always_comb begin
    hit = (bus_addr == REG_ADDR);
  end

  // Write classification
  always_comb begin
    kind = WR_NONE;
    if (bus_we && hit) begin
      if (special_mode) begin
        kind = WR_FREE;
      end else if (!lock_q) begin
        kind = WR_FIRST;
      end else begin
        kind = WR_BLOCKED;
      end
    end
  end

  // Next state and clock enables
  always_comb begin
    page_d  = page_q;
    lock_d  = lock_q;
    page_en = 1'b0;
    lock_en = 1'b0;
    unique case (kind)
      WR_FREE: begin
        page_d  = bus_wdata;
        page_en = 1'b1;
      end
      WR_FIRST: begin
        page_d  = bus_wdata;
        page_en = 1'b1;
        lock_d  = 1'b1;
        lock_en = 1'b1;
      end
      WR_BLOCKED: begin
        page_en = 1'b0;
      end
      default: begin
        page_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_en) begin
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  // Read path
  always_comb begin
    bus_rdata = hit ? page_q : '0;
  end

endmodule

// File: rtl/dpg_addr_form.sv
module dpg_addr_form
  import dpg_pkg::*;
#(
  parameter int unsigned PAGE_W  = DPG_PAGE_W,
  parameter int unsigned OPER_W  = DPG_OPER_W,
  parameter int unsigned GPAGE_W = DPG_GPAGE_W,
  localparam int unsigned LOC_W  = PAGE_W + OPER_W,
  localparam int unsigned GLB_W  = GPAGE_W + LOC_W
) (
  input  logic [PAGE_W-1:0]  page,
  input  logic [OPER_W-1:0]  dir_operand,
  input  logic               glob_access,
  input  logic [GPAGE_W-1:0] gpage_in,
  input  logic [GPAGE_W-1:0] lexp_in,
  output logic [LOC_W-1:0]   local_addr,
  output logic [GLB_W-1:0]   global_addr
);

  logic [GPAGE_W-1:0] upper;

  always_comb begin
    local_addr = {page, dir_operand};
  end

  // Upper global bits: per-bit select between the two sources
  for (genvar gi = 0; gi < int'(GPAGE_W); gi++) begin : g_upper
    always_comb begin
      upper[gi] = glob_access ? gpage_in[gi] : lexp_in[gi];
    end
  end

  always_comb begin
    global_addr = {upper, local_addr};
  end

endmodule

// File: rtl/dpg_top.sv
module dpg_top
  import dpg_pkg::*;
#(
  parameter int unsigned        PAGE_W   = DPG_PAGE_W,
  parameter int unsigned        OPER_W   = DPG_OPER_W,
  parameter int unsigned        GPAGE_W  = DPG_GPAGE_W,
  parameter int unsigned        BUS_AW   = DPG_BUS_AW,
  parameter logic [BUS_AW-1:0]  REG_ADDR = 5'h04,
  localparam int unsigned       LOC_W    = PAGE_W + OPER_W,
  localparam int unsigned       GLB_W    = GPAGE_W + LOC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               special_mode,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [PAGE_W-1:0]  bus_wdata,
  output logic [PAGE_W-1:0]  bus_rdata,
  input  logic [OPER_W-1:0]  dir_operand,
  input  logic               glob_access,
  input  logic [GPAGE_W-1:0] gpage_in,
  input  logic [GPAGE_W-1:0] lexp_in,
  output logic [LOC_W-1:0]   local_addr,
  output logic [GLB_W-1:0]   global_addr
);

  logic              rst_sync_n;
  logic [PAGE_W-1:0] page_q;
  logic              lock_q;

  dpg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpg_page_reg #(
    .PAGE_W   (PAGE_W),
    .BUS_AW   (BUS_AW),
    .REG_ADDR (REG_ADDR)
  ) u_reg (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .special_mode (special_mode),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .page_q       (page_q),
    .lock_q       (lock_q)
  );

  dpg_addr_form #(
    .PAGE_W  (PAGE_W),
    .OPER_W  (OPER_W),
    .GPAGE_W (GPAGE_W)
  ) u_addr (
    .page        (page_q),
    .dir_operand (dir_operand),
    .glob_access (glob_access),
    .gpage_in    (gpage_in),
    .lexp_in     (lexp_in),
    .local_addr  (local_addr),
    .global_addr (global_addr)
  );

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned OPER_W  = 8,
  parameter int unsigned GPAGE_W = 7,
  parameter int unsigned BUS_AW  = 5,
  parameter logic [BUS_AW-1:0] REG_ADDR = 5'h04
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        special_mode,
  input logic [BUS_AW-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [PAGE_W-1:0]           bus_wdata,
  input logic [PAGE_W-1:0]           bus_rdata,
  input logic [OPER_W-1:0]           dir_operand,
  input logic                        glob_access,
  input logic [GPAGE_W-1:0]          gpage_in,
  input logic [GPAGE_W-1:0]          lexp_in,
  input logic [PAGE_W+OPER_W-1:0]    local_addr,
  input logic [GPAGE_W+PAGE_W+OPER_W-1:0] global_addr,
  input logic [PAGE_W-1:0]           page_q,
  input logic                        lock_q
);

  localparam int unsigned LOC_W = PAGE_W + OPER_W;

  AST_SPECIAL_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && special_mode && bus_addr == REG_ADDR) |=> (bus_rdata == $past(bus_wdata) || bus_addr != REG_ADDR)); // R3

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lock_q && !special_mode) |=> (page_q == $past(page_q))); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> lock_q); // R4

  AST_SPECIAL_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lock_q && special_mode) |=> !lock_q); // R5

  AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr != REG_ADDR) |=> (page_q == $past(page_q) && lock_q == $past(lock_q))); // R9

  always_comb begin
    if (rst_sync_n) begin
      AST_LOCAL_FORM: assert (local_addr == {page_q, dir_operand}); // R6
      AST_GLOBAL_UPPER: assert (global_addr[LOC_W +: GPAGE_W] == (glob_access ? gpage_in : lexp_in)); // R7
      AST_GLOBAL_LOWER: assert (global_addr[LOC_W-1:0] == local_addr); // R8
    end
  end

endmodule

bind dpg_top dpg_checker #(
  .PAGE_W   (PAGE_W),
  .OPER_W   (OPER_W),
  .GPAGE_W  (GPAGE_W),
  .BUS_AW   (BUS_AW),
  .REG_ADDR (REG_ADDR)
) u_dpg_checker (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .special_mode (special_mode),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .dir_operand  (dir_operand),
  .glob_access  (glob_access),
  .gpage_in     (gpage_in),
  .lexp_in      (lexp_in),
  .local_addr   (local_addr),
  .global_addr  (global_addr),
  .page_q       (page_q),
  .lock_q       (lock_q)
);

// File: tb/tb_dpg_top.sv
module tb_dpg_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] REG_A = 5'h04;

  logic        clk;
  logic        rst_n;
  logic        special_mode;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  dir_operand;
  logic        glob_access;
  logic [6:0]  gpage_in;
  logic [6:0]  lexp_in;
  logic [15:0] local_addr;
  logic [22:0] global_addr;

  int total = 0;
  int bad   = 0;

  dpg_top dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .dir_operand  (dir_operand),
    .glob_access  (glob_access),
    .gpage_in     (gpage_in),
    .lexp_in      (lexp_in),
    .local_addr   (local_addr),
    .global_addr  (global_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic t_reset_state();
    read_chk("R1 reset value", REG_A, 8'h00);
    read_chk("R2 other address reads zero", 5'h05, 8'h00);
  endtask

  task automatic t_special_writes();
    special_mode = 1'b1;
    bus_write(REG_A, 8'h12);
    read_chk("R3 special write 1", REG_A, 8'h12);
    bus_write(REG_A, 8'hA5);
    read_chk("R3 special write 2", REG_A, 8'hA5);
    bus_write(REG_A, 8'h3C);
    read_chk("R3 special write 3", REG_A, 8'h3C);
  endtask

  task automatic t_normal_lock();
    special_mode = 1'b0;
    bus_write(REG_A, 8'h80);
    read_chk("R5 normal write after special accepted", REG_A, 8'h80);
    bus_write(REG_A, 8'h33);
    read_chk("R4 second normal write ignored", REG_A, 8'h80);
    special_mode = 1'b1;
    bus_write(REG_A, 8'h44);
    read_chk("R3 special write after lock", REG_A, 8'h44);
    special_mode = 1'b0;
    bus_write(REG_A, 8'h55);
    read_chk("R4 still locked", REG_A, 8'h44);
  endtask

  task automatic t_other_addr();
    special_mode = 1'b1;
    bus_write(5'h05, 8'h77);
    read_chk("R9 page unchanged by other address", REG_A, 8'h44);
    read_chk("R2 other address still zero", 5'h1F, 8'h00);
  endtask

  task automatic t_relock_after_reset();
    special_mode = 1'b0;
    do_reset();
    read_chk("R1 reset value again", REG_A, 8'h00);
    bus_write(5'h03, 8'h99);
    read_chk("R9 other-address normal write no effect", REG_A, 8'h00);
    bus_write(REG_A, 8'h5C);
    read_chk("R10 first normal write after reset", REG_A, 8'h5C);
    bus_write(REG_A, 8'hC5);
    read_chk("R4 later normal write ignored", REG_A, 8'h5C);
  endtask

  task automatic addr_chk(input logic [7:0] op, input logic g, input logic [6:0] gp,
                          input logic [6:0] lx, input logic [7:0] page);
    logic [15:0] exp_loc;
    logic [22:0] exp_glb;
    dir_operand = op;
    glob_access = g;
    gpage_in    = gp;
    lexp_in     = lx;
    #1;
    exp_loc = {page, op};
    exp_glb = g ? {gp, page, op} : {lx, page, op};
    chk("R6 local address", {16'd0, local_addr}, {16'd0, exp_loc});
    if (g) chk("R7 global direct address", {9'd0, global_addr}, {9'd0, exp_glb});
    else   chk("R8 local expanded address", {9'd0, global_addr}, {9'd0, exp_glb});
  endtask

  task automatic t_addresses();
    @(negedge clk);
    addr_chk(8'h00, 1'b1, 7'h7F, 7'h00, 8'h5C);
    addr_chk(8'hFF, 1'b1, 7'h01, 7'h55, 8'h5C);
    addr_chk(8'h80, 1'b0, 7'h7F, 7'h2A, 8'h5C);
    addr_chk(8'h01, 1'b0, 7'h00, 7'h7F, 8'h5C);
    special_mode = 1'b1;
    bus_write(REG_A, 8'hFF);
    addr_chk(8'hFF, 1'b1, 7'h7F, 7'h00, 8'hFF);
    addr_chk(8'h10, 1'b0, 7'h00, 7'h41, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    special_mode = 1'b0;
    bus_addr     = '0;
    bus_we       = 1'b0;
    bus_wdata    = '0;
    dir_operand  = '0;
    glob_access  = 1'b0;
    gpage_in     = '0;
    lexp_in      = '0;
    do_reset();
    t_reset_state();
    t_special_writes();
    t_normal_lock();
    t_other_addr();
    t_relock_after_reset();
    t_addresses();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule